// File: doc/BRIEF.md
# Commutated Center-Aligned Gate PWM

This block drives the six gate signals of a three-phase bridge: a top and a bottom switch for each phase. It runs a center-aligned PWM period counter. In every sector reported by the rotor position sensors, it modulates two phases with opposite polarity and holds the third phase fully off. A signed duty fraction sets the applied voltage. Its magnitude sets the amplitude and its sign sets which of the two driven phases gets the wider top pulse, and so the direction of rotation. Each top/bottom pair is complementary, with a programmable dead-time on both edges of every pulse.

The switching edges are placed symmetrically around the middle of the period. Each edge uses a half-width derived from the duty, the period and the dead-time. The half-widths are limited so that no pulse is shorter than a programmable minimum. A start request first holds every gate low for a bootstrap charge interval. The first PWM period then runs at zero duty. New duty and period values take effect only at period boundaries. A stop request or a falling edge on the active-low fault input turns all gates off, and the block stays off until it is started again.

Top module: `commutated_pwm`

## Requirements
- R1: After reset, and until a start request is accepted, all six gate outputs are low.
- R2: A start request (`start_i` high for one clock while idle and while the synchronized fault level is high) holds all gates low for STARTUP_TICKS clocks. Gates are switching from the clock edge STARTUP_TICKS+1 edges after the one that took the request. At that first edge the bottom gates of both driven phases are high and every top gate is low.
- R3: The first PWM period after start runs at zero duty whatever `duty_i` holds. Duty and period inputs are taken only when the period counter wraps, so a change made inside a period does not alter the pulse in progress.
- R4: With period T, signed duty fraction dc (Q1.15 two's complement), Tdc = floor(dc·T/2^15), X = floor((T+Tdc)/2) (after the R9 limit), Y = T−X, A = floor((X−DT)/2), B = floor((X+DT)/2), C = floor((Y−DT)/2) and D = floor((Y+DT)/2). The positive phase top pulse lasts 2A clocks and its bottom high time is T−2B clocks per period. The negative phase uses 2C and T−2D in the same way. All windows are centred on period floor(T/2).
- R5: Within a phase the top and bottom gates are never high together. The gap between a top falling edge and the following bottom rising edge is DT clocks.
- R6: The sector (3-bit) picks the roles of phases A, B and C (gate bits 1:0, 3:2, 5:4; top is the even bit) as positive/negative/off. Sector 4 gives A/B/off, sector 6 gives A/off/B... as positive A, negative C. Sector 2 gives positive B, negative C. Sector 3 gives positive B, negative A. Sector 1 gives positive C, negative A. Sector 5 gives positive C, negative B. The remaining phase has both gates low.
- R7: Sector codes 0 and 7 turn all six gates off.
- R8: A negative duty makes the positive phase top pulse narrower than the negative phase top pulse, which reverses the applied voltage.
- R9: X is limited to the range [MPW+DT, T−MPW−DT], so no top or bottom pulse is shorter than MPW clocks.
- R10: A stop request turns all gates off within two clocks, and they stay off until a new start.
- R11: A falling edge of the synchronized fault input turns all gates off within four clocks of the pin change. The gates stay off after the pin returns high until a new start, and a start request is ignored while the level is low. `fault_level_o` reports the synchronized pin level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one PWM tick per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request (bootstrap charge, then run) |
| stop_i | input | 1 | Stop request, all gates off |
| fault_n_i | input | 1 | Active-low fault pin, asynchronous |
| sector_i | input | 3 | Rotor sector code (1..6 legal) |
| duty_i | input | DUTY_W | Signed Q1.15 duty fraction in [−1,1) |
| period_i | input | CNT_W | PWM period in clocks |
| deadtime_i | input | CNT_W | Dead-time in clocks (static) |
| minpulse_i | input | CNT_W | Minimum pulse width in clocks (static) |
| gate_o | output | 6 | Gate drives {C bot, C top, B bot, B top, A bot, A top} |
| fault_level_o | output | 1 | Synchronized fault pin level |

## Verification
The hardest case to reach is the loading rule. It must be shown that a duty change arriving in the middle of a pulse leaves that pulse untouched, while the next pulse follows the new value. The stimulus waits for the positive top gate to rise and then rewrites the duty on that same cycle. The scoreboard expects the old width for the current pulse and the new width for the next one. The first period after start, which runs at zero duty, is reached by preloading a non-zero duty before the start request. The first two top pulses are then measured.

// File: rtl/bcp_pkg.sv
package bcp_pkg;

   localparam int NUM_PHASES = 3;

   typedef enum logic [1:0] {
      ROLE_OFF = 2'd0,
      ROLE_POS = 2'd1,
      ROLE_NEG = 2'd2
   } role_e;

   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_CHARGE = 2'd1,
      ST_RUN    = 2'd2
   } run_state_e;

   // Role of one phase for a given rotor sector; illegal codes switch all off.
   function automatic role_e phase_role(input logic [2:0] sector, input int phase);
      int   pos_ph;
      int   neg_ph;
      logic legal;
      legal  = 1'b1;
      pos_ph = 0;
      neg_ph = 0;
      case (sector)
         3'd4:    begin pos_ph = 0; neg_ph = 1; end
         3'd6:    begin pos_ph = 0; neg_ph = 2; end
         3'd2:    begin pos_ph = 1; neg_ph = 2; end
         3'd3:    begin pos_ph = 1; neg_ph = 0; end
         3'd1:    begin pos_ph = 2; neg_ph = 0; end
         3'd5:    begin pos_ph = 2; neg_ph = 1; end
         default: legal = 1'b0;
      endcase
      if (!legal)               return ROLE_OFF;
      else if (phase == pos_ph) return ROLE_POS;
      else if (phase == neg_ph) return ROLE_NEG;
      else                      return ROLE_OFF;
   endfunction

endpackage

// File: rtl/bcp_run_ctrl.sv
module bcp_run_ctrl
   import bcp_pkg::*;
#(
   parameter int STARTUP_TICKS = 32000,
   parameter int SYNC_STAGES   = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic stop_i,
   input  logic fault_n_i,
   output logic run_o,
   output logic fault_level_o
);

   localparam int CHG_W = $clog2(STARTUP_TICKS + 1);
   localparam logic [CHG_W-1:0] CHG_LAST = CHG_W'(STARTUP_TICKS - 1);

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   level_prev_q;
   logic                   fault_fall;
   logic                   level_now;
   run_state_e             state_q;
   logic [CHG_W-1:0]       chg_q;

   // Synchronizer depth chosen by parameter
   if (SYNC_STAGES == 1) begin : g_sync_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= fault_n_i;
      end
   end else begin : g_sync_many
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_q <= '0;
         else        sync_q <= {sync_q[SYNC_STAGES-2:0], fault_n_i};
      end
   end

   assign level_now  = sync_q[SYNC_STAGES-1];
   assign fault_fall = level_prev_q & ~level_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_prev_q <= 1'b0;
      else        level_prev_q <= level_now;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         chg_q   <= '0;
      end else if (fault_fall || stop_i) begin
         state_q <= ST_IDLE;
         chg_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               chg_q <= '0;
               if (start_i && level_now) state_q <= ST_CHARGE;
            end
            ST_CHARGE: begin
               if (chg_q == CHG_LAST) state_q <= ST_RUN;
               else                   chg_q   <= chg_q + 1'b1;
            end
            ST_RUN:  state_q <= ST_RUN;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign run_o         = (state_q == ST_RUN);
   assign fault_level_o = level_now;

endmodule

// File: rtl/bcp_period_timer.sv
module bcp_period_timer #(
   parameter int CNT_W  = 16,
   parameter int DUTY_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     run_i,
   input  logic signed [DUTY_W-1:0] duty_i,
   input  logic [CNT_W-1:0]         period_i,
   output logic [CNT_W-1:0]         cnt_o,
   output logic signed [DUTY_W-1:0] duty_act_o,
   output logic [CNT_W-1:0]         period_act_o
);

   logic [CNT_W-1:0]         cnt_q;
   logic signed [DUTY_W-1:0] duty_q;
   logic [CNT_W-1:0]         per_q;
   logic                     wrap;

   assign wrap = (cnt_q == per_q - 1'b1);

   // While stopped the shadow copy holds zero duty and tracks the period input,
   // so the first running period uses zero duty.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         duty_q <= '0;
         per_q  <= '0;
      end else if (!run_i) begin
         cnt_q  <= '0;
         duty_q <= '0;
         per_q  <= period_i;
      end else if (wrap) begin
         cnt_q  <= '0;
         duty_q <= duty_i;
         per_q  <= period_i;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign cnt_o        = cnt_q;
   assign duty_act_o   = duty_q;
   assign period_act_o = per_q;

endmodule

// File: rtl/bcp_edge_calc.sv
module bcp_edge_calc #(
   parameter int CNT_W    = 16,
   parameter int DUTY_W   = 16,
   parameter bit CLAMP_EN = 1'b1
) (
   input  logic signed [DUTY_W-1:0] duty_i,
   input  logic [CNT_W-1:0]         period_i,
   input  logic [CNT_W-1:0]         deadtime_i,
   input  logic [CNT_W-1:0]         minpulse_i,
   output logic [CNT_W-1:0]         center_o,
   output logic [CNT_W-1:0]         half_pt_o,
   output logic [CNT_W-1:0]         half_pb_o,
   output logic [CNT_W-1:0]         half_nt_o,
   output logic [CNT_W-1:0]         half_nb_o
);

   localparam int PW = DUTY_W + CNT_W + 1;
   localparam int EW = CNT_W + 2;

   logic signed [PW-1:0] prod;
   logic signed [EW-1:0] per_s, dt_s, mpw_s;
   logic signed [EW-1:0] tdc, x_raw, x_lo, x_hi, x_cl, y_cl;

   assign per_s = $signed({2'b00, period_i});
   assign dt_s  = $signed({2'b00, deadtime_i});

   // Variant: with clamping off only the dead-time bounds the half-widths
   if (CLAMP_EN) begin : g_clamp
      assign mpw_s = $signed({2'b00, minpulse_i});
   end else begin : g_noclamp
      assign mpw_s = '0;
   end

   always_comb begin
      prod  = PW'(duty_i) * PW'($signed({1'b0, period_i}));
      tdc   = EW'(prod >>> (DUTY_W - 1));
      x_raw = (per_s + tdc) >>> 1;
      x_lo  = dt_s + mpw_s;
      x_hi  = per_s - dt_s - mpw_s;
      x_cl  = x_raw;
      if (x_cl > x_hi) x_cl = x_hi;
      if (x_cl < x_lo) x_cl = x_lo;
      y_cl  = per_s - x_cl;
   end

   assign center_o  = period_i >> 1;
   assign half_pt_o = CNT_W'((x_cl - dt_s) >>> 1);
   assign half_pb_o = CNT_W'((x_cl + dt_s) >>> 1);
   assign half_nt_o = CNT_W'((y_cl - dt_s) >>> 1);
   assign half_nb_o = CNT_W'((y_cl + dt_s) >>> 1);

endmodule

// File: rtl/bcp_phase_gate.sv
module bcp_phase_gate
   import bcp_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  role_e            role_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] center_i,
   input  logic [CNT_W-1:0] half_pt_i,
   input  logic [CNT_W-1:0] half_pb_i,
   input  logic [CNT_W-1:0] half_nt_i,
   input  logic [CNT_W-1:0] half_nb_i,
   output logic             top_o,
   output logic             bot_o
);

   logic top_d, bot_d;
   logic top_q, bot_q;

   // True when cnt lies in [center-half, center+half)
   function automatic logic in_window(input logic [CNT_W-1:0] cnt,
                                      input logic [CNT_W-1:0] ctr,
                                      input logic [CNT_W-1:0] half);
      logic [CNT_W:0] lo_side, hi_side;
      lo_side = {1'b0, cnt} + {1'b0, half};
      hi_side = {1'b0, ctr} + {1'b0, half};
      return (lo_side >= {1'b0, ctr}) && ({1'b0, cnt} < hi_side);
   endfunction

   always_comb begin
      top_d = 1'b0;
      bot_d = 1'b0;
      case (role_i)
         ROLE_POS: begin
            top_d = in_window(cnt_i, center_i, half_pt_i);
            bot_d = !in_window(cnt_i, center_i, half_pb_i);
         end
         ROLE_NEG: begin
            top_d = in_window(cnt_i, center_i, half_nt_i);
            bot_d = !in_window(cnt_i, center_i, half_nb_i);
         end
         default: begin
            top_d = 1'b0;
            bot_d = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         top_q <= 1'b0;
         bot_q <= 1'b0;
      end else if (!run_i) begin
         top_q <= 1'b0;
         bot_q <= 1'b0;
      end else begin
         top_q <= top_d;
         bot_q <= bot_d;
      end
   end

   assign top_o = top_q;
   assign bot_o = bot_q;

endmodule

// File: rtl/commutated_pwm.sv
module commutated_pwm
   import bcp_pkg::*;
#(
   parameter int CNT_W         = 16,
   parameter int DUTY_W        = 16,
   parameter int STARTUP_TICKS = 32000,
   parameter int SYNC_STAGES   = 2,
   parameter bit CLAMP_EN      = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     start_i,
   input  logic                     stop_i,
   input  logic                     fault_n_i,
   input  logic [2:0]               sector_i,
   input  logic signed [DUTY_W-1:0] duty_i,
   input  logic [CNT_W-1:0]         period_i,
   input  logic [CNT_W-1:0]         deadtime_i,
   input  logic [CNT_W-1:0]         minpulse_i,
   output logic [5:0]               gate_o,
   output logic                     fault_level_o
);

   localparam int GATES = 2 * NUM_PHASES;

   if (CNT_W < 4) begin : g_bad_cnt
      $error("commutated_pwm: CNT_W must be at least 4");
   end
   if (DUTY_W < 2) begin : g_bad_duty
      $error("commutated_pwm: DUTY_W must be at least 2");
   end
   if (STARTUP_TICKS < 1) begin : g_bad_start
      $error("commutated_pwm: STARTUP_TICKS must be at least 1");
   end
   if (SYNC_STAGES < 1 || SYNC_STAGES > 3) begin : g_bad_sync
      $error("commutated_pwm: SYNC_STAGES must be 1..3");
   end
   if (GATES != 6) begin : g_bad_gates
      $error("commutated_pwm: gate vector sized for three phases");
   end

   logic                     run;
   logic [CNT_W-1:0]         cnt;
   logic signed [DUTY_W-1:0] duty_act;
   logic [CNT_W-1:0]         per_act;
   logic [CNT_W-1:0]         center, h_pt, h_pb, h_nt, h_nb;

   bcp_run_ctrl #(
      .STARTUP_TICKS (STARTUP_TICKS),
      .SYNC_STAGES   (SYNC_STAGES)
   ) u_ctrl (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .stop_i        (stop_i),
      .fault_n_i     (fault_n_i),
      .run_o         (run),
      .fault_level_o (fault_level_o)
   );

   bcp_period_timer #(
      .CNT_W  (CNT_W),
      .DUTY_W (DUTY_W)
   ) u_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .run_i        (run),
      .duty_i       (duty_i),
      .period_i     (period_i),
      .cnt_o        (cnt),
      .duty_act_o   (duty_act),
      .period_act_o (per_act)
   );

   bcp_edge_calc #(
      .CNT_W    (CNT_W),
      .DUTY_W   (DUTY_W),
      .CLAMP_EN (CLAMP_EN)
   ) u_edges (
      .duty_i     (duty_act),
      .period_i   (per_act),
      .deadtime_i (deadtime_i),
      .minpulse_i (minpulse_i),
      .center_o   (center),
      .half_pt_o  (h_pt),
      .half_pb_o  (h_pb),
      .half_nt_o  (h_nt),
      .half_nb_o  (h_nb)
   );

   for (genvar p = 0; p < NUM_PHASES; p++) begin : g_phase
      role_e role_w;
      assign role_w = phase_role(sector_i, p);

      bcp_phase_gate #(
         .CNT_W (CNT_W)
      ) u_gate (
         .clk       (clk),
         .rst_n     (rst_n),
         .run_i     (run),
         .role_i    (role_w),
         .cnt_i     (cnt),
         .center_i  (center),
         .half_pt_i (h_pt),
         .half_pb_i (h_pb),
         .half_nt_i (h_nt),
         .half_nb_i (h_nb),
         .top_o     (gate_o[2*p]),
         .bot_o     (gate_o[2*p+1])
      );
   end

endmodule

// File: rtl/commutated_pwm_chk.sv
module commutated_pwm_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       stop_i,
   input logic [2:0] sector_i,
   input logic [5:0] gate_o,
   input logic       fault_level_o
);

   assert_no_shoot_through_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(gate_o[0] && gate_o[1]) && !(gate_o[2] && gate_o[3]) && !(gate_o[4] && gate_o[5]));

   assert_illegal_sector_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sector_i == 3'd0 || sector_i == 3'd7) |=> (gate_o == 6'b0));

   assert_idle_phase_a_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sector_i == 3'd2 || sector_i == 3'd5) |=> (gate_o[1:0] == 2'b00));

   assert_idle_phase_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sector_i == 3'd6 || sector_i == 3'd1) |=> (gate_o[3:2] == 2'b00));

   assert_idle_phase_c_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (sector_i == 3'd4 || sector_i == 3'd3) |=> (gate_o[5:4] == 2'b00));

   assert_stop_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i |-> ##2 (gate_o == 6'b0));

   assert_fault_off_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fault_level_o) |-> ##2 (gate_o == 6'b0));

endmodule

bind commutated_pwm commutated_pwm_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .stop_i        (stop_i),
   .sector_i      (sector_i),
   .gate_o        (gate_o),
   .fault_level_o (fault_level_o)
);

// File: tb/commutated_pwm_test.sv
`timescale 1ns/1ps
module commutated_pwm_test;

   localparam int STARTUP  = 50;
   localparam int WATCHDOG = 150000;
   localparam int GUARD    = 2000;

   logic               clk = 1'b0;
   logic               rst_n;
   logic               start_i, stop_i, fault_n_i;
   logic [2:0]         sector_i;
   logic signed [15:0] duty_i;
   logic [15:0]        period_i, deadtime_i, minpulse_i;
   logic [5:0]         gate_o;
   logic               fault_level_o;

   int checks   = 0;
   int failures = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   commutated_pwm #(
      .CNT_W         (16),
      .DUTY_W        (16),
      .STARTUP_TICKS (STARTUP),
      .SYNC_STAGES   (2),
      .CLAMP_EN      (1'b1)
   ) uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .start_i       (start_i),
      .stop_i        (stop_i),
      .fault_n_i     (fault_n_i),
      .sector_i      (sector_i),
      .duty_i        (duty_i),
      .period_i      (period_i),
      .deadtime_i    (deadtime_i),
      .minpulse_i    (minpulse_i),
      .gate_o        (gate_o),
      .fault_level_o (fault_level_o)
   );

   // kind 0: pulse width of gate idx; 1: phase idx (3 = all) stays low; 2: dead gap top idx -> idx+1
   typedef struct {
      int    kind;
      int    idx;
      int    exp;
      string req;
   } sb_item_t;

   sb_item_t sb_q[$];

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   // Expected half-widths straight from the R4/R9 formulas
   function automatic void calc(input int dc, input int t, input int dt, input int mpw,
                                output int a, output int b, output int c, output int d);
      int tdc, x, y;
      tdc = (dc * t) >>> 15;
      x   = (t + tdc) >>> 1;
      if (x > t - dt - mpw) x = t - dt - mpw;
      if (x < dt + mpw)     x = dt + mpw;
      y = t - x;
      a = (x - dt) >>> 1;
      b = (x + dt) >>> 1;
      c = (y - dt) >>> 1;
      d = (y + dt) >>> 1;
   endfunction

   function automatic int pos_phase(input int s);
      case (s)
         4, 6:    return 0;
         2, 3:    return 1;
         default: return 2;
      endcase
   endfunction

   function automatic int neg_phase(input int s);
      case (s)
         4, 5:    return 1;
         6, 2:    return 2;
         default: return 0;
      endcase
   endfunction

   // ---------------- monitor ----------------
   task automatic meas_width(input int idx, output int w);
      int g = 0;
      w = -1;
      while (gate_o[idx] !== 1'b0 && g < GUARD) begin @(negedge clk); g++; end
      while (gate_o[idx] !== 1'b1 && g < GUARD) begin @(negedge clk); g++; end
      if (g >= GUARD) return;
      w = 0;
      while (gate_o[idx] === 1'b1 && w < GUARD) begin w++; @(negedge clk); end
   endtask

   task automatic meas_gap(input int idx, output int w);
      int g = 0;
      w = -1;
      while (gate_o[idx] !== 1'b1 && g < GUARD) begin @(negedge clk); g++; end
      while (gate_o[idx] !== 1'b0 && g < GUARD) begin @(negedge clk); g++; end
      if (g >= GUARD) return;
      w = 0;
      while (gate_o[idx+1] === 1'b0 && w < GUARD) begin w++; @(negedge clk); end
   endtask

   task automatic meas_quiet(input int ph, output int highs);
      highs = 0;
      for (int i = 0; i < 300; i++) begin
         @(negedge clk);
         if (ph == 3) highs += $countones(gate_o);
         else         highs += int'(gate_o[2*ph]) + int'(gate_o[2*ph+1]);
      end
   endtask

   initial begin : monitor
      sb_item_t it;
      int got;
      forever begin
         wait (sb_q.size() != 0);
         it = sb_q[0];
         case (it.kind)
            0: begin
               meas_width(it.idx, got);
               check(got == it.exp, it.req, $sformatf("pulse width gate%0d", it.idx), got, it.exp);
            end
            1: begin
               meas_quiet(it.idx, got);
               check(got == 0, it.req, $sformatf("high samples on phase sel %0d", it.idx), got, 0);
            end
            default: begin
               meas_gap(it.idx, got);
               check(got == it.exp, it.req, $sformatf("dead gap after gate%0d", it.idx), got, it.exp);
            end
         endcase
         void'(sb_q.pop_front());
      end
   end

   // ---------------- driver helpers ----------------
   task automatic push(input int kind, input int idx, input int exp, input string req);
      sb_item_t it;
      it.kind = kind; it.idx = idx; it.exp = exp; it.req = req;
      sb_q.push_back(it);
   endtask

   task automatic drain();
      wait (sb_q.size() == 0);
      @(negedge clk);
   endtask

   task automatic start_and_check(input string req);
      @(negedge clk) start_i = 1'b1;
      @(posedge clk);
      @(negedge clk) start_i = 1'b0;
      repeat (STARTUP) @(posedge clk);
      @(negedge clk);
      check(gate_o == 6'b0, req, "gates during charge", int'(gate_o), 0);
      @(posedge clk);
      @(negedge clk);
      check(gate_o == 6'b001010, req, "gates at first run edge", int'(gate_o), 6'b001010);
   endtask

   task automatic settle();
      repeat (250) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (WATCHDOG) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
      finish_run();
   end

   // ---------------- stimulus ----------------
   initial begin : driver
      int a, b, c, d;
      int a0, b0, c0, d0;
      int t, dt, mpw;
      int seq[5] = '{6, 2, 3, 1, 5};

      t = 100; dt = 4; mpw = 6;
      rst_n = 1'b0; start_i = 1'b0; stop_i = 1'b0; fault_n_i = 1'b1;
      sector_i = 3'd4; duty_i = 16'sd16384;
      period_i = 16'(t); deadtime_i = 16'(dt); minpulse_i = 16'(mpw);
      repeat (4) @(negedge clk);
      check(gate_o == 6'b0, "R1", "gates in reset", int'(gate_o), 0);
      rst_n = 1'b1;
      push(1, 3, 0, "R1");
      drain();

      // R2 start-up, R3 first period at zero duty
      calc(0, t, dt, mpw, a0, b0, c0, d0);
      calc(16384, t, dt, mpw, a, b, c, d);
      start_and_check("R2");
      push(0, 0, 2*a0, "R3");
      push(0, 0, 2*a,  "R4");
      drain();

      // R4 all four widths in sector 4, R6 idle phase C, R5 dead gaps
      push(0, 1, t - 2*b, "R4");
      push(0, 2, 2*c,     "R4");
      push(0, 3, t - 2*d, "R4");
      push(1, 2, 0,       "R6");
      push(2, 0, dt,      "R5");
      push(2, 2, dt,      "R5");
      drain();

      // R3 boundary loading: change duty right as the top pulse starts
      begin
         int an, bn, cn, dn;
         calc(-16384, t, dt, mpw, an, bn, cn, dn);
         push(0, 0, 2*a,  "R3");
         push(0, 0, 2*an, "R3");
         while (gate_o[0] !== 1'b0) @(negedge clk);
         while (gate_o[0] !== 1'b1) @(negedge clk);
         duty_i = -16'sd16384;
         drain();
         // R8 negative duty: positive phase top narrower than negative phase top
         settle();
         push(0, 0, 2*an, "R8");
         push(0, 2, 2*cn, "R8");
         drain();
         check(2*an < 2*cn, "R8", "pos top narrower than neg top", 2*an, 2*cn);
      end

      // R6 remaining sectors
      duty_i = 16'sd16384;
      settle();
      foreach (seq[i]) begin
         @(negedge clk) sector_i = 3'(seq[i]);
         repeat (3) @(negedge clk);
         push(0, 2*pos_phase(seq[i]), 2*a, "R6");
         push(0, 2*neg_phase(seq[i]), 2*c, "R6");
         push(1, 3 - pos_phase(seq[i]) - neg_phase(seq[i]), 0, "R6");
         drain();
      end

      // R7 illegal sectors
      @(negedge clk) sector_i = 3'd0;
      push(1, 3, 0, "R7");
      drain();
      sector_i = 3'd7;
      push(1, 3, 0, "R7");
      drain();
      sector_i = 3'd4;

      // R9 minimum pulse clamp at both duty extremes
      duty_i = 16'sh7FFF;
      settle();
      push(0, 1, mpw, "R9");
      push(0, 2, mpw, "R9");
      drain();
      duty_i = -16'sh8000;
      settle();
      push(0, 0, mpw, "R9");
      drain();

      // R4 with a different period
      duty_i = 16'sd16384;
      period_i = 16'd60;
      settle();
      calc(16384, 60, dt, mpw, a, b, c, d);
      push(0, 0, 2*a,      "R4");
      push(0, 1, 60 - 2*b, "R4");
      drain();
      period_i = 16'(t);
      settle();

      // R10 stop
      @(negedge clk) stop_i = 1'b1;
      @(negedge clk) stop_i = 1'b0;
      @(negedge clk);
      check(gate_o == 6'b0, "R10", "gates after stop", int'(gate_o), 0);
      push(1, 3, 0, "R10");
      drain();
      start_and_check("R2");
      settle();

      // R11 fault
      @(negedge clk) fault_n_i = 1'b0;
      repeat (5) @(negedge clk);
      check(gate_o == 6'b0, "R11", "gates after fault edge", int'(gate_o), 0);
      check(fault_level_o == 1'b0, "R11", "fault level low", int'(fault_level_o), 0);
      fault_n_i = 1'b1;
      repeat (5) @(negedge clk);
      check(fault_level_o == 1'b1, "R11", "fault level high", int'(fault_level_o), 1);
      push(1, 3, 0, "R11");
      drain();
      // start ignored while fault held low
      fault_n_i = 1'b0;
      repeat (5) @(negedge clk);
      start_i = 1'b1;
      @(negedge clk) start_i = 1'b0;
      fault_n_i = 1'b1;
      push(1, 3, 0, "R11");
      drain();
      start_and_check("R11");
      push(0, 0, 2*a0, "R11");
      drain();

      finish_run();
   end

endmodule